// File: doc/BRIEF.md
# Floppy Controller Host Command/Result Sequencer

This block is the part of a floppy disk controller that the host processor talks to. It has two byte-wide registers. A read-only status register tells the host that the block is ready and in which direction data flows. A data register takes in command bytes and hands back result bytes. The block collects the bytes of a command and uses the opcode in the first byte to learn how many command bytes follow and how many result bytes the command returns. It then gives the command to an execution stage with a one-cycle start pulse.

The execution stage is outside this block. It ends a command by pulsing a done input while it drives a full array of result bytes. The sequencer latches those bytes and raises an interrupt unless the command was sense-interrupt-status. It then hands the bytes to the host one read at a time and goes back to collecting commands after the last one. A command with no result bytes goes straight back to the command phase when execution ends.

Top module: `fdc_cmd_seq`

## Requirements
- R1: Register address 0 reads the status register and address 1 reads the data register. Addresses 2 and 3 read 0xFF.
- R2: The status register reads 0x80 in the command phase and 0xC0 in the execute and result phases. Bit 7 is always 1, bit 6 is the direction flag, and bits 5..0 are 0.
- R3: The opcode is bits 4..0 of the first command byte. Command lengths are 9 bytes for opcodes 0x02, 0x05, 0x06, 0x09, 0x0C, 0x11, 0x19 and 0x1D. They are 6 for 0x0D, 3 for 0x03 and 0x0F, 2 for 0x04, 0x07 and 0x0A, 1 for 0x08, and 1 for every other opcode.
- R4: The clock cycle after the last command byte is written, exec_start is high for exactly one cycle. During that cycle exec_opcode holds the opcode and byte k of exec_cmd (bits 8k+7..8k) holds command byte k.
- R5: Result lengths are 7 bytes for the nine-byte family, 0x0A and 0x0D. They are 2 for 0x08, 1 for 0x04 and for undefined opcodes, and 0 for 0x03, 0x07 and 0x0F. Successive data reads in the result phase return result bytes 0, 1, 2 and so on. These are the bytes from byte k of exec_result at the done pulse.
- R6: When a command with result length 0 receives exec_done, the next cycle is in the command phase.
- R7: exec_done in the execute phase sets irq, except for opcode 0x08, which clears irq instead.
- R8: Each data read in the result phase clears irq. The read of the last result byte returns the block to the command phase.
- R9: A data read outside the result phase returns result byte 0. It changes neither the phase, nor the position in the result sequence, nor irq.
- R10: A data write outside the command phase is ignored, and so is any write to address 0.
- R11: After reset the block is in the command phase with irq and exec_start low, and result byte 0 reads 0x00.
- R12: A data read in the same cycle as exec_done returns the previous result byte 0. The newly latched bytes then start from byte 0, and irq is left set.
- R13: exec_done outside the execute phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe, advances the result sequence |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register |
| exec_start | output | 1 | One-cycle pulse when a command is complete |
| exec_opcode | output | 5 | Opcode of the current command |
| exec_cmd | output | 72 | Command bytes, byte k at bits 8k+7..8k |
| exec_done | input | 1 | Execution finished, result array valid |
| exec_result | input | 56 | Result bytes, byte k at bits 8k+7..8k |
| irq | output | 1 | Interrupt request |

## Verification
The coincidence that matters is a host read of the data register in the same cycle as the execution stage's done pulse. Both can touch the result store and the interrupt. The bench provokes it by reading while still in the execute phase and asserting exec_done in that same cycle with a new result array. It expects the stale byte 0 on the bus, the interrupt set afterwards, and the first proper result read returning the new byte 0. A behavioural model compares the read bus, interrupt and start pulse on every clock through all command types.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_t;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_DATA   = 2'd1;

  localparam logic [OPC_W-1:0] OP_RD_TRACK   = 5'h02;
  localparam logic [OPC_W-1:0] OP_SPECIFY    = 5'h03;
  localparam logic [OPC_W-1:0] OP_SENSE_DRV  = 5'h04;
  localparam logic [OPC_W-1:0] OP_WR_DATA    = 5'h05;
  localparam logic [OPC_W-1:0] OP_RD_DATA    = 5'h06;
  localparam logic [OPC_W-1:0] OP_RECAL      = 5'h07;
  localparam logic [OPC_W-1:0] OP_SENSE_INT  = 5'h08;
  localparam logic [OPC_W-1:0] OP_WR_DEL     = 5'h09;
  localparam logic [OPC_W-1:0] OP_RD_ID      = 5'h0A;
  localparam logic [OPC_W-1:0] OP_RD_DEL     = 5'h0C;
  localparam logic [OPC_W-1:0] OP_FORMAT     = 5'h0D;
  localparam logic [OPC_W-1:0] OP_SEEK       = 5'h0F;
  localparam logic [OPC_W-1:0] OP_SCAN_EQ    = 5'h11;
  localparam logic [OPC_W-1:0] OP_SCAN_LE    = 5'h19;
  localparam logic [OPC_W-1:0] OP_SCAN_HE    = 5'h1D;

endpackage

// File: rtl/fdc_opc_decode.sv
module fdc_opc_decode
  import fdc_seq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [OPC_W-1:0] opc,
  output logic [LEN_W-1:0] cmd_len,
  output logic [LEN_W-1:0] res_len
);

  always_comb begin
    unique case (opc)
      OP_RD_TRACK, OP_WR_DATA, OP_RD_DATA, OP_WR_DEL,
      OP_RD_DEL, OP_SCAN_EQ, OP_SCAN_LE, OP_SCAN_HE: begin
        cmd_len = LEN_W'(9);
        res_len = LEN_W'(7);
      end
      OP_RD_ID: begin
        cmd_len = LEN_W'(2);
        res_len = LEN_W'(7);
      end
      OP_RECAL: begin
        cmd_len = LEN_W'(2);
        res_len = LEN_W'(0);
      end
      OP_FORMAT: begin
        cmd_len = LEN_W'(6);
        res_len = LEN_W'(7);
      end
      OP_SENSE_INT: begin
        cmd_len = LEN_W'(1);
        res_len = LEN_W'(2);
      end
      OP_SPECIFY, OP_SEEK: begin
        cmd_len = LEN_W'(3);
        res_len = LEN_W'(0);
      end
      OP_SENSE_DRV: begin
        cmd_len = LEN_W'(2);
        res_len = LEN_W'(1);
      end
      default: begin
        cmd_len = LEN_W'(1);
        res_len = LEN_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/fdc_cmd_collect.sv
module fdc_cmd_collect
  import fdc_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CMD_MAX = 9,
  parameter int IDX_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [DW-1:0]         wbyte,
  output logic                  last_byte,
  output logic [OPC_W-1:0]      opcode,
  output logic [IDX_W-1:0]      res_len,
  output logic [CMD_MAX*DW-1:0] cmd_flat
);

  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [OPC_W-1:0]      op_q;
  logic [IDX_W-1:0]      clen_q, rlen_q;
  logic [IDX_W-1:0]      dec_clen, dec_rlen;
  logic [IDX_W-1:0]      eff_clen;
  logic                  first_byte;
  logic [CMD_MAX*DW-1:0] cmd_q;

  fdc_opc_decode #(.LEN_W(IDX_W)) u_dec (
    .opc     (wbyte[OPC_W-1:0]),
    .cmd_len (dec_clen),
    .res_len (dec_rlen)
  );

  assign first_byte = (idx_q == '0);
  assign eff_clen   = first_byte ? dec_clen : clen_q;
  assign last_byte  = accept && ((idx_q + IDX_W'(1)) == eff_clen);

  always_comb begin
    idx_d = idx_q;
    if (accept) begin
      idx_d = last_byte ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (accept) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      clen_q <= '0;
      rlen_q <= '0;
    end else if (accept && first_byte) begin
      op_q   <= wbyte[OPC_W-1:0];
      clen_q <= dec_clen;
      rlen_q <= dec_rlen;
    end
  end

  for (genvar k = 0; k < CMD_MAX; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q[k*DW +: DW] <= '0;
      end else if (accept && (idx_q == IDX_W'(k))) begin
        cmd_q[k*DW +: DW] <= wbyte;
      end
    end
  end

  assign opcode   = op_q;
  assign res_len  = rlen_q;
  assign cmd_flat = cmd_q;

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(CMD_MAX));

  a_r3_single_byte_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first_byte && (wbyte[OPC_W-1:0] == OP_SENSE_INT)) |=> (idx_q == '0));

endmodule

// File: rtl/fdc_res_stage.sv
module fdc_res_stage #(
  parameter int DW      = 8,
  parameter int RES_MAX = 7,
  parameter int IDX_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [RES_MAX*DW-1:0] res_in,
  input  logic                  pop,
  input  logic [IDX_W-1:0]      res_len,
  output logic                  last_pop,
  output logic [DW-1:0]         cur_byte,
  output logic [DW-1:0]         first_res
);

  logic [RES_MAX*DW-1:0] res_q;
  logic [IDX_W-1:0]      ridx_q, ridx_d;

  assign last_pop = pop && ((ridx_q + IDX_W'(1)) == res_len);

  always_comb begin
    ridx_d = ridx_q;
    if (capture) begin
      ridx_d = '0;
    end else if (pop) begin
      ridx_d = last_pop ? '0 : ridx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
    end else if (capture || pop) begin
      ridx_q <= ridx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (capture) begin
      res_q <= res_in;
    end
  end

  always_comb begin
    if (ridx_q < IDX_W'(RES_MAX)) begin
      cur_byte = DW'(res_q >> (int'(ridx_q) * DW));
    end else begin
      cur_byte = '0;
    end
  end

  assign first_res = res_q[DW-1:0];

  a_r5_ridx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ridx_q < IDX_W'(RES_MAX));

  a_r12_capture_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ridx_q == '0));

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CMD_MAX = 9,
  parameter int RES_MAX = 7,
  parameter int IDX_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  exec_start,
  output logic [OPC_W-1:0]      exec_opcode,
  output logic [CMD_MAX*DW-1:0] exec_cmd,
  input  logic                  exec_done,
  input  logic [RES_MAX*DW-1:0] exec_result,
  output logic                  irq
);

  localparam logic [DW-1:0] ST_READY = DW'(8'h80);
  localparam logic [DW-1:0] ST_DIR   = DW'(8'h40);
  localparam logic [DW-1:0] RD_NONE  = {DW{1'b1}};

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  phase_t phase_q, phase_d;
  logic   irq_q, irq_d;
  logic   start_q, start_d;

  logic   data_wr, data_rd;
  logic   accept, capture, pop;
  logic   last_byte, last_pop;
  logic [IDX_W-1:0] res_len;
  logic [DW-1:0]    cur_byte, first_res;
  logic [OPC_W-1:0] opcode;

  assign data_wr = reg_wr && (reg_addr == A_DATA);
  assign data_rd = reg_rd && (reg_addr == A_DATA);
  assign accept  = data_wr && (phase_q == PH_CMD);
  assign capture = exec_done && (phase_q == PH_EXEC);
  assign pop     = data_rd && (phase_q == PH_RES);

  fdc_cmd_collect #(
    .DW(DW), .CMD_MAX(CMD_MAX), .IDX_W(IDX_W)
  ) u_collect (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .wbyte     (reg_wdata),
    .last_byte (last_byte),
    .opcode    (opcode),
    .res_len   (res_len),
    .cmd_flat  (exec_cmd)
  );

  fdc_res_stage #(
    .DW(DW), .RES_MAX(RES_MAX), .IDX_W(IDX_W)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture   (capture),
    .res_in    (exec_result),
    .pop       (pop),
    .res_len   (res_len),
    .last_pop  (last_pop),
    .cur_byte  (cur_byte),
    .first_res (first_res)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_CMD:  if (last_byte) phase_d = PH_EXEC;
      PH_EXEC: if (capture)   phase_d = (res_len == '0) ? PH_CMD : PH_RES;
      PH_RES:  if (last_pop)  phase_d = PH_CMD;
      default: phase_d = PH_CMD;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (capture) begin
      irq_d = (opcode != OP_SENSE_INT);
    end else if (pop) begin
      irq_d = 1'b0;
    end
  end

  assign start_d = accept && last_byte;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_CMD;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      irq_q   <= irq_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_STATUS: reg_rdata = ST_READY | ((phase_q != PH_CMD) ? ST_DIR : '0);
      A_DATA:   reg_rdata = (phase_q == PH_RES) ? cur_byte : first_res;
      default:  reg_rdata = RD_NONE;
    endcase
  end

  assign exec_start  = start_q;
  assign exec_opcode = opcode;
  assign irq         = irq_q;

  a_r4_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    exec_start |=> !exec_start);

  a_r4_start_in_exec: assert property (@(posedge clk) disable iff (!rst_int_n)
    exec_start |-> (phase_q == PH_EXEC));

  a_r6_no_result_back: assert property (@(posedge clk) disable iff (!rst_int_n)
    (capture && (res_len == '0)) |=> (phase_q == PH_CMD));

  a_r7_sense_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (capture && (opcode == OP_SENSE_INT)) |=> !irq);

  a_r8_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    pop |=> !irq);

  a_r13_irq_rises_from_exec: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_q != PH_EXEC) |=> !$rose(irq));

  a_r9_stray_read_keeps_phase: assert property (@(posedge clk) disable iff (!rst_int_n)
    (data_rd && (phase_q == PH_CMD) && !reg_wr) |=> (phase_q == PH_CMD));

endmodule

// File: tb/fdc_cmd_seq_tb_top.sv
module fdc_cmd_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        exec_start;
  logic [4:0]  exec_opcode;
  logic [71:0] exec_cmd;
  logic        exec_done;
  logic [55:0] exec_result;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  fdc_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exec_start(exec_start), .exec_opcode(exec_opcode), .exec_cmd(exec_cmd),
    .exec_done(exec_done), .exec_result(exec_result), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase, m_cnt, m_clen, m_rlen, m_op, m_ridx, ph;
  int m_cmd[16];
  int m_res[7];
  bit m_irq, m_start;

  task automatic lens(input int op, output int cl, output int rl);
    case (op)
      'h02, 'h05, 'h06, 'h09, 'h0C, 'h11, 'h19, 'h1D: begin cl = 9; rl = 7; end
      'h0A: begin cl = 2; rl = 7; end
      'h07: begin cl = 2; rl = 0; end
      'h0D: begin cl = 6; rl = 7; end
      'h08: begin cl = 1; rl = 2; end
      'h03, 'h0F: begin cl = 3; rl = 0; end
      'h04: begin cl = 2; rl = 1; end
      default: begin cl = 1; rl = 1; end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_clen = 1; m_rlen = 0; m_op = 0; m_ridx = 0;
      m_irq = 0; m_start = 0;
      for (int k = 0; k < 7; k++) m_res[k] = 0;
    end else begin
      ph = m_phase;
      m_start = 0;
      if (reg_wr && reg_addr == 2'd1 && ph == 0) begin
        if (m_cnt == 0) begin
          m_op = int'(reg_wdata[4:0]);
          lens(m_op, m_clen, m_rlen);
        end
        m_cmd[m_cnt] = int'(reg_wdata);
        m_cnt++;
        if (m_cnt == m_clen) begin
          m_phase = 1; m_start = 1; m_cnt = 0;
        end
      end
      if (ph == 1 && exec_done) begin
        for (int k = 0; k < 7; k++) m_res[k] = int'(exec_result[k*8 +: 8]);
        m_ridx = 0;
        m_phase = (m_rlen != 0) ? 2 : 0;
        m_irq = (m_op != 'h08);
      end
      if (reg_rd && reg_addr == 2'd1 && ph == 2) begin
        m_ridx++;
        m_irq = 0;
        if (m_ridx == m_rlen) m_phase = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      int exp_rd;
      string tag;
      #3;
      case (reg_addr)
        2'd0: begin exp_rd = 'h80 | ((m_phase != 0) ? 'h40 : 0); tag = "R2"; end
        2'd1: begin
          exp_rd = (m_phase == 2) ? m_res[m_ridx] : m_res[0];
          tag = (m_phase == 2) ? "R5" : "R9";
        end
        default: begin exp_rd = 'hFF; tag = "R1"; end
      endcase
      chk(int'(reg_rdata) == exp_rd, tag, int'(reg_rdata), exp_rd);
      chk(irq == m_irq, "R7", int'(irq), int'(m_irq));
      chk(exec_start == m_start, "R4", int'(exec_start), int'(m_start));
      if (m_start) begin
        chk(int'(exec_opcode) == m_op, "R4", int'(exec_opcode), m_op);
        for (int k = 0; k < m_clen; k++)
          chk(int'(exec_cmd[k*8 +: 8]) == m_cmd[k], "R4", int'(exec_cmd[k*8 +: 8]), m_cmd[k]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic [1:0] a, input logic w, input logic r,
                       input logic [7:0] d, input logic dn);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; exec_done = dn;
    #3;
  endtask

  task automatic idle();
    drive(2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic rd_expect(input logic [1:0] a, input int exp, input string req);
    drive(a, 1'b0, 1'b1, 8'h00, 1'b0);
    chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
  endtask

  task automatic status_expect(input int exp, input string req);
    idle();
    chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
  endtask

  task automatic send(input int bytes[$]);
    foreach (bytes[i]) begin
      drive(2'd1, 1'b1, 1'b0, 8'(bytes[i]), 1'b0);
      status_expect((i == bytes.size() - 1) ? 'hC0 : 'h80, "R3");
    end
  endtask

  task automatic finish_exec(input logic [55:0] res, input int exp_irq, input string req);
    exec_result = res;
    drive(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
    idle();
    chk(int'(irq) == exp_irq, req, int'(irq), exp_irq);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    reg_addr = 2'd0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    exec_done = 0; exec_result = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #3;
    chk(irq == 1'b0, "R11", int'(irq), 0);
    chk(exec_start == 1'b0, "R11", int'(exec_start), 0);
    chk(int'(reg_rdata) == 'h80, "R11", int'(reg_rdata), 'h80);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_on = 1;

    // R11: result byte 0 after reset, R9: stray read
    rd_expect(2'd1, 'h00, "R11");
    status_expect('h80, "R9");
    // R1: unused addresses
    rd_expect(2'd2, 'hFF, "R1");
    rd_expect(2'd3, 'hFF, "R1");

    // specify: three bytes, no result
    send('{'h03, 'hDF, 'h02});
    finish_exec(56'h0, 1, "R7");
    status_expect('h80, "R6");

    // R13: done outside execute ignored
    drive(2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
    idle();
    chk(irq == 1'b1, "R13", int'(irq), 1);
    status_expect('h80, "R13");

    // R10: write to status address is not a command byte
    drive(2'd0, 1'b1, 1'b0, 8'h0F, 1'b0);
    // sense-interrupt: one byte, clears irq
    send('{'h08});
    finish_exec(56'h00000000001B20, 0, "R7");
    rd_expect(2'd1, 'h20, "R5");
    rd_expect(2'd1, 'h1B, "R5");
    status_expect('h80, "R8");

    // read data, nine bytes with MFM bit set
    send('{'h46, 'h01, 'h02, 'h00, 'h03, 'h01, 'h1A, 'h2A, 'hFF});
    // R9: read in execute returns old byte 0, no effect
    rd_expect(2'd1, 'h20, "R9");
    chk(irq == 1'b0, "R9", int'(irq), 0);
    status_expect('hC0, "R9");
    finish_exec(56'h01_05_00_02_00_00_41, 1, "R7");
    rd_expect(2'd1, 'h41, "R5");
    idle();
    chk(irq == 1'b0, "R8", int'(irq), 0);
    // R10: write in result phase ignored
    drive(2'd1, 1'b1, 1'b0, 8'h08, 1'b0);
    rd_expect(2'd1, 'h00, "R10");
    rd_expect(2'd1, 'h00, "R5");
    rd_expect(2'd1, 'h02, "R5");
    rd_expect(2'd1, 'h00, "R5");
    rd_expect(2'd1, 'h05, "R5");
    status_expect('hC0, "R8");
    rd_expect(2'd1, 'h01, "R5");
    status_expect('h80, "R8");

    // undefined opcode: one byte, one result
    send('{'h1F});
    finish_exec(56'h80, 1, "R7");
    rd_expect(2'd1, 'h80, "R5");
    status_expect('h80, "R3");

    // R12: sense-drive; read coincides with done
    send('{'h04, 'h05});
    exec_result = 56'h33;
    drive(2'd1, 1'b0, 1'b1, 8'h00, 1'b1);
    chk(int'(reg_rdata) == 'h80, "R12", int'(reg_rdata), 'h80);
    idle();
    chk(irq == 1'b1, "R12", int'(irq), 1);
    chk(int'(reg_rdata) == 'hC0, "R12", int'(reg_rdata), 'hC0);
    rd_expect(2'd1, 'h33, "R12");
    status_expect('h80, "R12");

    // format, seek, recalibrate, read-id
    send('{'h4D, 'h00, 'h02, 'h09, 'h1B, 'hE5});
    finish_exec(56'h02_00_00_05_00_00_04, 1, "R7");
    for (int k = 0; k < 7; k++) drive(2'd1, 1'b0, 1'b1, 8'h00, 1'b0);
    status_expect('h80, "R5");
    send('{'h0F, 'h01, 'h10});
    finish_exec(56'h0, 1, "R6");
    status_expect('h80, "R6");
    send('{'h07, 'h00});
    finish_exec(56'h0, 1, "R6");
    status_expect('h80, "R6");
    send('{'h4A, 'h00});
    finish_exec(56'h02_01_00_00_00_00_00, 1, "R7");
    for (int k = 0; k < 6; k++) drive(2'd1, 1'b0, 1'b1, 8'h00, 1'b0);
    rd_expect(2'd1, 'h02, "R5");
    status_expect('h80, "R8");

    repeat (3) idle();
    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule